// File: doc/BRIEF.md
# Function-Level Reset Handshake Responder

This block is the user-side partner of a PCIe endpoint controller during a function-level reset. The controller raises a per-function "reset active" flag for any of its physical functions (4 by default) or virtual functions (64 by default). For each flagged function the responder closes the door on new requests, waits until every transaction that function still has in flight has retired, and then raises that function's done flag. It keeps done high until the controller lowers the active flag, then returns to rest.

Each function has its own small state machine, so all 68 handshakes can run at once without affecting one another. Virtual functions are grouped under physical functions in contiguous blocks: virtual function `n` belongs to physical function `n / VF_PER_PF`, with 16 per group by default. A reset of a physical function drives every virtual function in its group through the same drain sequence. The physical function reports done only after its whole group has drained. The user datapath supplies an outstanding-transaction count for each function and honours a per-function block output. All signals share one clock.

Top module: `flr_responder`

## Requirements
- R1: After synchronous reset every done output and every block output is 0.
- R2: When a function's active flag is sampled high at a clock edge while that function is at rest, its block output is 1 immediately after that edge. It stays 1 until the cycle after the flag is seen low.
- R3: A function's done output never rises while its outstanding count is nonzero. For a virtual function whose count is zero, done rises 3 clock edges after the active flag is first sampled high.
- R4: Once done is 1, it stays 1 for as long as the active flag stays high, even if the outstanding count becomes nonzero.
- R5: On the first edge that samples the active flag low while done is 1, done and block both go to 0.
- R6: A physical function's active flag also sets in motion every virtual function `v` with `v / VF_PER_PF` equal to that physical function's index. Those virtual functions block and raise done as if their own flags were set. They return to rest once both the physical flag and their own flag are low.
- R7: A physical function's done rises only after every virtual function in its group shows done, and one edge later than the last of them. A single virtual function with a nonzero count holds the physical function's done at 0.
- R8: If the active flag falls before done has been raised, the function goes back to rest on the next edge with done still 0. Done stays 0 afterwards.
- R9: Functions outside a reset's group are unaffected by it. Concurrent resets of different functions each complete on their own timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all handshake signals |
| rst | input | 1 | Synchronous active-high reset |
| pf_active_i | input | NUM_PF | Reset-active flag per physical function |
| vf_active_i | input | NUM_VF | Reset-active flag per virtual function |
| pf_pending_i | input | NUM_PF*CNT_W | Outstanding transaction count per physical function, function p at bits [p*CNT_W +: CNT_W] |
| vf_pending_i | input | NUM_VF*CNT_W | Outstanding transaction count per virtual function, function v at bits [v*CNT_W +: CNT_W] |
| pf_done_o | output | NUM_PF | Done flag per physical function |
| vf_done_o | output | NUM_VF | Done flag per virtual function |
| pf_block_o | output | NUM_PF | Refuse new requests for this physical function |
| vf_block_o | output | NUM_VF | Refuse new requests for this virtual function |

## Verification
A channel stuck in the wrong state appears at the ports within one or two edges. Done can rise early while the count is still nonzero, or fail to appear within three edges of a clean start. Block can stay high after the flag drops, or done can survive the fall of the flag. A group-map fault appears as a physical reset that fails to block its own virtual functions, or that blocks another group's. A wrong gating term lets the physical done rise while one of its virtual functions is still draining. Each scenario samples at the exact edge the requirement predicts, so a fault that only shifts timing by one cycle is also reported.

// File: rtl/flr_pkg.sv
package flr_pkg;

    typedef enum logic [1:0] {
        CH_REST    = 2'd0,
        CH_DRAIN   = 2'd1,
        CH_CONFIRM = 2'd2,
        CH_DONE    = 2'd3
    } ch_state_e;

    typedef struct packed {
        logic done;
        logic block;
    } ch_out_t;

    function automatic int unsigned owner_pf(input int unsigned vf_idx,
                                             input int unsigned per_pf);
        return vf_idx / per_pf;
    endfunction

endpackage

// File: rtl/flr_channel.sv
module flr_channel
    import flr_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active_i,
    input  logic [CNT_W-1:0] pending_i,
    input  logic             group_ok_i,
    output ch_out_t          out_o
);

    ch_state_e state_q, state_d;
    logic      idle_cnt;

    assign idle_cnt = (pending_i == '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_REST: begin
                if (active_i) state_d = CH_DRAIN;
            end
            CH_DRAIN: begin
                if (!active_i)     state_d = CH_REST;
                else if (idle_cnt) state_d = CH_CONFIRM;
            end
            CH_CONFIRM: begin
                if (!active_i)       state_d = CH_REST;
                else if (!idle_cnt)  state_d = CH_DRAIN;
                else if (group_ok_i) state_d = CH_DONE;
            end
            CH_DONE: begin
                if (!active_i) state_d = CH_REST;
            end
            default: state_d = CH_REST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= CH_REST;
        else     state_q <= state_d;
    end

    assign out_o.done  = (state_q == CH_DONE);
    assign out_o.block = (state_q != CH_REST);

    // R3
    done_needs_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(out_o.done) |-> $past(idle_cnt));

    // R4
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_o.done && active_i) |=> out_o.done);

    // R5
    done_release_chk: assert property (@(posedge clk) disable iff (rst)
        (out_o.done && !active_i) |=> (!out_o.done && !out_o.block));

    // R8
    abort_no_done_chk: assert property (@(posedge clk) disable iff (rst)
        (!active_i && !out_o.done) |=> !out_o.done);

    // R2
    block_start_chk: assert property (@(posedge clk) disable iff (rst)
        (active_i && !out_o.block) |=> out_o.block);

endmodule

// File: rtl/flr_group_map.sv
module flr_group_map
    import flr_pkg::*;
#(
    parameter int unsigned NUM_PF    = 4,
    parameter int unsigned NUM_VF    = 64,
    parameter int unsigned VF_PER_PF = 16
) (
    input  logic [NUM_PF-1:0] pf_active_i,
    input  logic [NUM_VF-1:0] vf_active_i,
    input  logic [NUM_VF-1:0] vf_done_i,
    output logic [NUM_VF-1:0] vf_eff_active_o,
    output logic [NUM_PF-1:0] pf_group_ok_o
);

    localparam int unsigned MAPPED_VF = NUM_PF * VF_PER_PF;

    for (genvar v = 0; v < NUM_VF; v++) begin : g_vf
        if (v < MAPPED_VF) begin : g_owned
            assign vf_eff_active_o[v] = vf_active_i[v] | pf_active_i[owner_pf(v, VF_PER_PF)];
        end else begin : g_free
            assign vf_eff_active_o[v] = vf_active_i[v];
        end
    end

    for (genvar p = 0; p < NUM_PF; p++) begin : g_pf
        if ((p + 1) * VF_PER_PF <= NUM_VF) begin : g_full
            assign pf_group_ok_o[p] = &vf_done_i[p*VF_PER_PF +: VF_PER_PF];
        end else begin : g_none
            assign pf_group_ok_o[p] = 1'b1;
        end
    end

endmodule

// File: rtl/flr_responder.sv
module flr_responder
    import flr_pkg::*;
#(
    parameter int unsigned NUM_PF    = 4,
    parameter int unsigned NUM_VF    = 64,
    parameter int unsigned VF_PER_PF = 16,
    parameter int unsigned CNT_W     = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_PF-1:0]       pf_active_i,
    input  logic [NUM_VF-1:0]       vf_active_i,
    input  logic [NUM_PF*CNT_W-1:0] pf_pending_i,
    input  logic [NUM_VF*CNT_W-1:0] vf_pending_i,
    output logic [NUM_PF-1:0]       pf_done_o,
    output logic [NUM_VF-1:0]       vf_done_o,
    output logic [NUM_PF-1:0]       pf_block_o,
    output logic [NUM_VF-1:0]       vf_block_o
);

    logic [NUM_VF-1:0] vf_eff_active;
    logic [NUM_PF-1:0] pf_group_ok;
    ch_out_t           pf_out [NUM_PF];
    ch_out_t           vf_out [NUM_VF];

    flr_group_map #(
        .NUM_PF    (NUM_PF),
        .NUM_VF    (NUM_VF),
        .VF_PER_PF (VF_PER_PF)
    ) u_map (
        .pf_active_i     (pf_active_i),
        .vf_active_i     (vf_active_i),
        .vf_done_i       (vf_done_o),
        .vf_eff_active_o (vf_eff_active),
        .pf_group_ok_o   (pf_group_ok)
    );

    for (genvar v = 0; v < NUM_VF; v++) begin : g_vf_ch
        flr_channel #(.CNT_W(CNT_W)) u_ch (
            .clk        (clk),
            .rst        (rst),
            .active_i   (vf_eff_active[v]),
            .pending_i  (vf_pending_i[v*CNT_W +: CNT_W]),
            .group_ok_i (1'b1),
            .out_o      (vf_out[v])
        );
        assign vf_done_o[v]  = vf_out[v].done;
        assign vf_block_o[v] = vf_out[v].block;
    end

    for (genvar p = 0; p < NUM_PF; p++) begin : g_pf_ch
        flr_channel #(.CNT_W(CNT_W)) u_ch (
            .clk        (clk),
            .rst        (rst),
            .active_i   (pf_active_i[p]),
            .pending_i  (pf_pending_i[p*CNT_W +: CNT_W]),
            .group_ok_i (pf_group_ok[p]),
            .out_o      (pf_out[p])
        );
        assign pf_done_o[p]  = pf_out[p].done;
        assign pf_block_o[p] = pf_out[p].block;

        if ((p + 1) * VF_PER_PF <= NUM_VF) begin : g_grp_chk
            // R7
            pf_after_group_chk: assert property (@(posedge clk) disable iff (rst)
                $rose(pf_done_o[p]) |-> $past(&vf_done_o[p*VF_PER_PF +: VF_PER_PF]));

            // R6
            pf_forces_group_chk: assert property (@(posedge clk) disable iff (rst)
                (pf_active_i[p] && pf_block_o[p]) |-> &vf_block_o[p*VF_PER_PF +: VF_PER_PF]);
        end
    end

endmodule

// File: tb/flr_responder_tb.sv
module flr_responder_tb;

    localparam int unsigned NPF = 4;
    localparam int unsigned NVF = 64;
    localparam int unsigned PER = 16;
    localparam int unsigned CW  = 8;

    logic              clk = 1'b0;
    logic              rst;
    logic [NPF-1:0]    pf_act;
    logic [NVF-1:0]    vf_act;
    logic [NPF*CW-1:0] pf_pend;
    logic [NVF*CW-1:0] vf_pend;
    logic [NPF-1:0]    pf_done, pf_blk;
    logic [NVF-1:0]    vf_done, vf_blk;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    flr_responder #(.NUM_PF(NPF), .NUM_VF(NVF), .VF_PER_PF(PER), .CNT_W(CW)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .pf_active_i  (pf_act),
        .vf_active_i  (vf_act),
        .pf_pending_i (pf_pend),
        .vf_pending_i (vf_pend),
        .pf_done_o    (pf_done),
        .vf_done_o    (vf_done),
        .pf_block_o   (pf_blk),
        .vf_block_o   (vf_blk)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quiet();
        pf_act = '0; vf_act = '0; pf_pend = '0; vf_pend = '0;
        step(2);
    endtask

    task automatic t_reset();
        rst = 1'b1; pf_act = '0; vf_act = '0; pf_pend = '0; vf_pend = '0;
        step(2);
        rst = 1'b0;
        step(1);
        chk("R1 done idle", {pf_done, vf_done[59:0]}, 64'd0);
        chk("R1 block idle", {pf_blk, vf_blk[59:0]}, 64'd0);
    endtask

    task automatic t_vf_clean();
        vf_act[3] = 1'b1;
        step(1);
        chk("R2 block rises", vf_blk[3], 1'b1);
        chk("R2 others free", vf_blk & ~(64'd1 << 3), 64'd0);
        step(1);
        chk("R3 done not yet", vf_done[3], 1'b0);
        step(1);
        chk("R3 done at 3rd edge", vf_done[3], 1'b1);
        chk("R9 pf untouched", pf_done | pf_blk, 4'd0);
        vf_pend[3*CW +: CW] = 8'd9;
        step(3);
        chk("R4 done held", vf_done[3], 1'b1);
        vf_act[3] = 1'b0;
        step(1);
        chk("R5 done drops", vf_done[3], 1'b0);
        chk("R5 block drops", vf_blk[3], 1'b0);
        quiet();
    endtask

    task automatic t_vf_pending();
        vf_pend[10*CW +: CW] = 8'd4;
        vf_act[10] = 1'b1;
        step(6);
        chk("R3 held by count", vf_done[10], 1'b0);
        chk("R2 block while draining", vf_blk[10], 1'b1);
        vf_pend[10*CW +: CW] = 8'd0;
        step(1);
        chk("R3 one edge after drain", vf_done[10], 1'b0);
        step(1);
        chk("R3 done after drain", vf_done[10], 1'b1);
        vf_act[10] = 1'b0;
        step(1);
        chk("R5 done clears", {vf_done[10], vf_blk[10]}, 2'b00);
        quiet();
    endtask

    task automatic t_abort();
        vf_pend[5*CW +: CW] = 8'd2;
        vf_act[5] = 1'b1;
        step(3);
        chk("R8 blocked pre-abort", vf_blk[5], 1'b1);
        vf_act[5] = 1'b0;
        step(1);
        chk("R8 back to rest", {vf_done[5], vf_blk[5]}, 2'b00);
        vf_pend[5*CW +: CW] = 8'd0;
        step(4);
        chk("R8 no late done", {vf_done[5], vf_blk[5]}, 2'b00);
        quiet();
    endtask

    task automatic t_pf_clean();
        pf_act[2] = 1'b1;
        step(1);
        chk("R6 group blocked", vf_blk[47:32], 16'hFFFF);
        chk("R9 other groups free", {vf_blk[63:48], vf_blk[31:0]}, 48'd0);
        chk("R2 pf block", pf_blk[2], 1'b1);
        step(2);
        chk("R6 group done", vf_done[47:32], 16'hFFFF);
        chk("R7 pf waits one edge", pf_done[2], 1'b0);
        step(1);
        chk("R7 pf done", pf_done[2], 1'b1);
        pf_act[2] = 1'b0;
        step(1);
        chk("R6 group released", {vf_done[47:32], vf_blk[47:32]}, 32'd0);
        chk("R5 pf released", {pf_done[2], pf_blk[2]}, 2'b00);
        quiet();
    endtask

    task automatic t_pf_gated();
        vf_pend[20*CW +: CW] = 8'd3;
        pf_act[1] = 1'b1;
        step(8);
        chk("R7 pf held by vf20", pf_done[1], 1'b0);
        chk("R3 vf20 held", vf_done[20], 1'b0);
        chk("R6 siblings done", {vf_done[31:21], vf_done[19:16]}, 15'h7FFF);
        vf_pend[20*CW +: CW] = 8'd0;
        step(2);
        chk("R7 vf20 done first", {vf_done[20], pf_done[1]}, 2'b10);
        step(1);
        chk("R7 pf follows", pf_done[1], 1'b1);
        pf_act[1] = 1'b0;
        step(1);
        chk("R6 own flag low releases", vf_blk[31:16], 16'd0);
        quiet();
    endtask

    task automatic t_concurrent();
        vf_pend[40*CW +: CW] = 8'd1;
        vf_act[40] = 1'b1;
        vf_act[41] = 1'b1;
        pf_act[0]  = 1'b1;
        step(3);
        chk("R9 vf41 done", vf_done[41], 1'b1);
        chk("R9 vf40 still draining", {vf_done[40], vf_blk[40]}, 2'b01);
        chk("R9 pf2 idle", {pf_done[2], pf_blk[2]}, 2'b00);
        step(1);
        chk("R9 pf0 done alongside", pf_done[0], 1'b1);
        vf_act[41] = 1'b0;
        step(1);
        chk("R9 vf40 unaffected", vf_blk[40], 1'b1);
        vf_pend[40*CW +: CW] = 8'd0;
        step(2);
        chk("R9 vf40 completes", vf_done[40], 1'b1);
        quiet();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_vf_clean();
        t_vf_pending();
        t_abort();
        t_pf_clean();
        t_pf_gated();
        t_concurrent();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule